// File: doc/BRIEF.md
# Reservation Monitor for Load-Locked / Store-Conditional

This block keeps one address reservation for each hardware thread context of a multithreaded core, and decides the outcome of every conditional store. Each context holds a reservation flag and the granule number (address with the low bits dropped) of its last locked load. Memory requests come in one per cycle on a single valid/ready port. Each request carries a context number, a physical address, a direction, a locked qualifier and an uncacheable qualifier.

A conditional store from a context succeeds only if that context still holds a reservation on the same granule. Every store that is actually performed clears the matching reservations in all contexts. A successful conditional store and a plain store are performed; an uncacheable conditional store is also performed, without any check. A per-context counter of consecutive failed conditional stores produces a periodic warning pulse that names the context, so that livelock can be detected. The block does not hold data, translate addresses or write the result register. It only produces the outcome code and the warning.

Top module: `resv_monitor`

## Requirements
- R1: A locked read from context c stores its address granule as c's reservation and sets c's flag. A plain read, without the locked qualifier, changes no reservation.
- R2: Granules are 2^GRAN_BITS bytes (16 by default). Two addresses match when they are equal after the low GRAN_BITS bits are dropped, so 0x40F and 0x400 match and 0x310 and 0x300 do not.
- R3: A cacheable conditional store fails when the issuer's flag is clear or its reserved granule differs from the store's granule. A failed store clears the issuer's flag and is not performed, so it clears no other context's reservation.
- R4: A cacheable conditional store returns code 1 if the issuer's flag was set before the check and code 0 if it was clear. A store with the flag set but the granule mismatched therefore returns 1 while still failing as in R3.
- R5: An uncacheable conditional store skips the reservation check, returns code 2 (no register update), zeroes the issuer's failure counter and is performed.
- R6: Each failed conditional store adds one to the issuer's consecutive-failure counter, and a success or an uncacheable conditional store zeroes it. When the count reaches WARN_PERIOD, the counter wraps to 0 and warn_valid pulses for one cycle with warn_ctx set to the issuer, in the same cycle as that store's result.
- R7: res_valid is high for exactly the one cycle after each accepted conditional store, and is low after every other request or idle cycle. res_code is 2 bits wide and takes only the values 0, 1 and 2.
- R8: Every performed store clears the flag of every context whose reserved granule matches the store's, the issuer included. A performed store is a plain write, a successful conditional store or an uncacheable conditional store. Reservations on other granules are kept.
- R9: After reset all flags are clear, all failure counters are zero, res_valid and warn_valid are low, and req_ready is high from the second cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_ctx | input | CTX_W | Issuing context number |
| req_addr | input | ADDR_W | Physical byte address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_locked | input | 1 | Locked load or conditional store |
| req_uncached | input | 1 | Uncacheable access |
| res_valid | output | 1 | Conditional store outcome valid |
| res_code | output | 2 | 0 fail, 1 success, 2 no register update |
| warn_valid | output | 1 | Failure-count warning pulse |
| warn_ctx | output | CTX_W | Context that raised the warning |

## Verification
The reservation outcome is tried with these patterns:
- A matching pair and a pair in the same granule at different byte offsets. These separate granule masking from exact-address compare.
- A store to the neighbouring granule, with the flag set. This exposes the quirk where the code is 1 but the store fails, which is then seen through the following store's code 0.
- A conditional store without a reservation, followed by the owner's store. This shows whether a failed store wrongly snoops other contexts.
- Plain stores inside and outside a reserved granule, and an uncacheable conditional store. These show which stores broadcast a clear.

The warning is driven with WARN_PERIOD set to 5. Runs of failures are broken by a success or by an uncacheable store, which separates "consecutive" from "total" counting.

// File: rtl/resv_pkg.sv
package resv_pkg;

   typedef enum logic [1:0] {
      RES_FAIL  = 2'd0,
      RES_OK    = 2'd1,
      RES_NOUPD = 2'd2
   } resv_code_e;

endpackage

// File: rtl/resv_slot.sv
// One context's reservation: flag plus reserved granule.
module resv_slot #(
   parameter int GRAN_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,       // locked load from this context
   input  logic [GRAN_W-1:0] set_gran_i,
   input  logic              kill_i,      // own conditional store failed
   input  logic              snoop_i,     // some store was performed
   input  logic [GRAN_W-1:0] snoop_gran_i,
   output logic              valid_o,
   output logic [GRAN_W-1:0] gran_o
);

   logic              valid_q;
   logic [GRAN_W-1:0] gran_q;
   logic              snoop_hit;

   assign snoop_hit = snoop_i && (gran_q == snoop_gran_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         gran_q  <= '0;
      end else begin
         if (set_i) begin
            valid_q <= 1'b1;
            gran_q  <= set_gran_i;
         end else if (kill_i || snoop_hit) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign valid_o = valid_q;
   assign gran_o  = gran_q;

endmodule

// File: rtl/fail_tracker.sv
// Consecutive conditional-store failure counter, wraps at PERIOD.
module fail_tracker #(
   parameter int PERIOD = 100000,
   localparam int CNT_W = $clog2(PERIOD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic zero_i,
   output logic hit_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last = (cnt_q == CNT_W'(PERIOD - 1));
   assign hit_o   = inc_i && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (zero_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
   import resv_pkg::*;
#(
   parameter int NUM_CTX     = 4,
   parameter int ADDR_W      = 32,
   parameter int GRAN_BITS   = 4,
   parameter int WARN_PERIOD = 100000,
   localparam int CTX_W      = $clog2(NUM_CTX),
   localparam int GRAN_W     = ADDR_W - GRAN_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_locked,
   input  logic              req_uncached,
   output logic              res_valid,
   output logic [1:0]        res_code,
   output logic              warn_valid,
   output logic [CTX_W-1:0]  warn_ctx
);

   if (NUM_CTX < 2) begin : g_bad_ctx
      $error("resv_monitor: NUM_CTX must be at least 2");
   end
   if (GRAN_BITS < 0 || GRAN_BITS >= ADDR_W) begin : g_bad_gran
      $error("resv_monitor: GRAN_BITS out of range");
   end
   if (WARN_PERIOD < 1) begin : g_bad_period
      $error("resv_monitor: WARN_PERIOD must be positive");
   end

   logic              ready_q;
   logic              fire;
   logic              ctx_ok;
   logic              is_ll, is_st, is_sc, sc_unc, sc_cac;
   logic              own_flag;
   logic [GRAN_W-1:0] own_gran;
   logic [GRAN_W-1:0] req_gran;
   logic              sc_pass, sc_fail, performed;

   logic [NUM_CTX-1:0] slot_valid;
   logic [GRAN_W-1:0]  slot_gran [NUM_CTX];
   logic [NUM_CTX-1:0] fail_hit;

   assign fire     = req_valid && ready_q;
   assign ctx_ok   = (32'(req_ctx) < NUM_CTX);
   assign req_gran = req_addr[ADDR_W-1:GRAN_BITS];

   assign is_ll  = fire && ctx_ok && !req_write && req_locked;
   assign is_st  = fire && req_write && !req_locked;
   assign is_sc  = fire && ctx_ok && req_write && req_locked;
   assign sc_unc = is_sc && req_uncached;
   assign sc_cac = is_sc && !req_uncached;

   always_comb begin
      own_flag = 1'b0;
      own_gran = '0;
      for (int i = 0; i < NUM_CTX; i++) begin
         if (32'(req_ctx) == i) begin
            own_flag = slot_valid[i];
            own_gran = slot_gran[i];
         end
      end
   end

   assign sc_pass   = sc_cac && own_flag && (own_gran == req_gran);
   assign sc_fail   = sc_cac && !sc_pass;
   assign performed = is_st || sc_pass || sc_unc;

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
      logic mine;
      assign mine = (32'(req_ctx) == g);

      resv_slot #(.GRAN_W(GRAN_W)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .set_i       (is_ll && mine),
         .set_gran_i  (req_gran),
         .kill_i      (sc_fail && mine),
         .snoop_i     (performed),
         .snoop_gran_i(req_gran),
         .valid_o     (slot_valid[g]),
         .gran_o      (slot_gran[g])
      );

      fail_tracker #(.PERIOD(WARN_PERIOD)) u_fail (
         .clk   (clk),
         .rst_n (rst_n),
         .inc_i (sc_fail && mine),
         .zero_i((sc_pass || sc_unc) && mine),
         .hit_o (fail_hit[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q    <= 1'b0;
         res_valid  <= 1'b0;
         res_code   <= RES_FAIL;
         warn_valid <= 1'b0;
         warn_ctx   <= '0;
      end else begin
         ready_q    <= 1'b1;
         res_valid  <= is_sc;
         if (is_sc) begin
            if (sc_unc)        res_code <= RES_NOUPD;
            else if (own_flag) res_code <= RES_OK;
            else               res_code <= RES_FAIL;
         end
         warn_valid <= |fail_hit;
         if (|fail_hit) warn_ctx <= req_ctx;
      end
   end

   assign req_ready = ready_q;

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
   parameter int NUM_CTX     = 4,
   parameter int ADDR_W      = 32,
   parameter int GRAN_BITS   = 4,
   parameter int WARN_PERIOD = 100000,
   localparam int CTX_W      = $clog2(NUM_CTX)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [CTX_W-1:0]  req_ctx,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic              req_locked,
   input logic              req_uncached,
   input logic              res_valid,
   input logic [1:0]        res_code,
   input logic              warn_valid,
   input logic [CTX_W-1:0]  warn_ctx
);

   logic sc_fire;
   assign sc_fire = req_valid && req_ready && req_write && req_locked;

   AST_SC_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      sc_fire |=> res_valid);                                          // R7
   AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_fire |=> !res_valid);                                        // R7
   AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_code != 2'd3));                               // R7
   AST_UNCACHED_NOUPD: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_fire && req_uncached) |=> (res_code == 2'd2));               // R5
   AST_WARN_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      warn_valid |-> (res_valid && res_code != 2'd2));                 // R6
   AST_WARN_NAMES_ISSUER: assert property (@(posedge clk) disable iff (!rst_n)
      warn_valid |-> (warn_ctx == $past(req_ctx)));                    // R6

endmodule

bind resv_monitor resv_monitor_chk #(
   .NUM_CTX    (NUM_CTX),
   .ADDR_W     (ADDR_W),
   .GRAN_BITS  (GRAN_BITS),
   .WARN_PERIOD(WARN_PERIOD)
) u_chk (.*);

// File: tb/resv_monitor_test.sv
`timescale 1ns/1ps
module resv_monitor_test;

   localparam int NCTX = 4;
   localparam int AW   = 32;
   localparam int PER  = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [1:0]      req_ctx = '0;
   logic [AW-1:0]   req_addr = '0;
   logic            req_write = 1'b0;
   logic            req_locked = 1'b0;
   logic            req_uncached = 1'b0;
   logic            res_valid;
   logic [1:0]      res_code;
   logic            warn_valid;
   logic [1:0]      warn_ctx;

   int checks = 0;
   int fails  = 0;
   logic got_rv, got_wv;
   logic [1:0] got_code, got_wc;

   always #2.5 clk = ~clk;

   resv_monitor #(.NUM_CTX(NCTX), .ADDR_W(AW), .GRAN_BITS(4), .WARN_PERIOD(PER)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ctx(req_ctx), .req_addr(req_addr), .req_write(req_write),
      .req_locked(req_locked), .req_uncached(req_uncached),
      .res_valid(res_valid), .res_code(res_code),
      .warn_valid(warn_valid), .warn_ctx(warn_ctx)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic issue(input int c, input logic [AW-1:0] a,
                        input logic w, input logic l, input logic u);
      @(negedge clk);
      req_valid = 1'b1; req_ctx = 2'(c); req_addr = a;
      req_write = w; req_locked = l; req_uncached = u;
      @(negedge clk);
      got_rv = res_valid; got_code = res_code;
      got_wv = warn_valid; got_wc = warn_ctx;
      req_valid = 1'b0;
   endtask

   task automatic ll(input int c, input logic [AW-1:0] a);
      issue(c, a, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic sc(input int c, input logic [AW-1:0] a, input int exp, input string tag);
      issue(c, a, 1'b1, 1'b1, 1'b0);
      check({tag, " valid"}, got_rv, 1);
      check({tag, " code"}, got_code, exp);
   endtask

   task automatic t_reset();
      check("R9 ready low in reset", req_ready, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R9 ready after reset", req_ready, 1);
      check("R9 no result", res_valid, 0);
      check("R9 no warn", warn_valid, 0);
      sc(0, 32'h100, 0, "R9 flag clear after reset");
   endtask

   task automatic t_basic();
      ll(0, 32'h100);
      check("R7 no result after load", got_rv, 0);
      sc(0, 32'h108, 1, "R1 R2 pair in granule");
      sc(0, 32'h100, 0, "R8 own store cleared issuer");
      ll(1, 32'h40F);
      sc(1, 32'h400, 1, "R2 granule boundary low");
   endtask

   task automatic t_no_resv();
      ll(1, 32'h200);
      sc(0, 32'h200, 0, "R3 no reservation");
      sc(1, 32'h200, 1, "R3 failed store not performed");
      issue(0, 32'h800, 1'b0, 1'b0, 1'b0);
      sc(0, 32'h800, 0, "R1 plain read no reservation");
   endtask

   task automatic t_mismatch();
      ll(0, 32'h300);
      sc(0, 32'h310, 1, "R4 flag set mismatch returns 1");
      sc(0, 32'h300, 0, "R3 mismatch cleared flag");
      ll(2, 32'h300);
      ll(0, 32'h300);
      sc(0, 32'h310, 1, "R4 mismatch again");
      sc(2, 32'h300, 1, "R3 mismatch store not performed");
   endtask

   task automatic t_broadcast();
      ll(2, 32'h500);
      ll(3, 32'h504);
      ll(1, 32'h600);
      issue(0, 32'h50C, 1'b1, 1'b0, 1'b0);
      check("R7 no result after plain store", got_rv, 0);
      issue(0, 32'h610, 1'b1, 1'b0, 1'b0);
      sc(2, 32'h500, 0, "R8 plain store cleared ctx2");
      sc(3, 32'h504, 0, "R8 plain store cleared ctx3");
      sc(1, 32'h600, 1, "R8 other granule kept");
   endtask

   task automatic t_uncached();
      ll(1, 32'h700);
      issue(0, 32'h700, 1'b1, 1'b1, 1'b1);
      check("R5 uncached valid", got_rv, 1);
      check("R5 uncached code", got_code, 2);
      sc(1, 32'h700, 0, "R5 uncached store performed");
   endtask

   task automatic t_warn();
      issue(3, 32'hF00, 1'b1, 1'b1, 1'b1);
      for (int k = 1; k <= PER; k++) begin
         sc(3, 32'hF00, 0, "R6 fail run");
         check("R6 warn at count", got_wv, (k == PER) ? 1 : 0);
      end
      check("R6 warn ctx", got_wc, 3);
      for (int k = 0; k < 3; k++) sc(3, 32'hF00, 0, "R6 partial run");
      ll(3, 32'hF00);
      sc(3, 32'hF04, 1, "R6 success");
      for (int k = 0; k < PER - 1; k++) begin
         sc(3, 32'hF00, 0, "R6 after success");
         check("R6 success reset counter", got_wv, 0);
      end
      issue(3, 32'hF00, 1'b1, 1'b1, 1'b1);
      for (int k = 1; k <= PER; k++) begin
         sc(3, 32'hF00, 0, "R6 after uncached");
         check("R5 R6 uncached reset counter", got_wv, (k == PER) ? 1 : 0);
      end
   endtask

   initial begin
      t_reset();
      t_basic();
      t_no_resv();
      t_mismatch();
      t_broadcast();
      t_uncached();
      t_warn();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule